// File: doc/BRIEF.md
# Audio Controller Interrupt Status Aggregator

This block gathers the interrupt sources of an audio controller into one 32-bit status word and turns that word into a single interrupt output. It has eight stream completion flags, two response-ring flags (interrupt and overrun), and a register of codec state-change bits that a wake-enable mask qualifies. Each status bit is gated by a matching bit of an interrupt control register, and these gated bits form a global summary bit. The output asserts when that summary bit and a master enable are both set.

The output has two signalling modes. In level mode it drives a wired interrupt line. In message mode the line stays low and a one-cycle notification pulse marks each rising edge of the computed level. A small register write port updates the control register and the wake-enable mask, and performs write-one-to-clear on the status word and on the codec state-change bits.

The status word is recomputed only when a source or an enable register changes. A status bit cleared by software therefore stays cleared while the condition that set it is unchanged. A controller reset clears the registers and loads the state-change bits from the map of attached codecs.

Top module: `irq_status_agg`

## Requirements
- R1: Status bit i (i = 0..7) equals the completion flag of stream i (`stream_done_i[i]`) once the status word has been recomputed. Status bits 29..8 always read zero.
- R2: Status bit 30 (controller summary) is set when at least one of these holds: the response-ring interrupt flag, the response-ring overrun flag, or a codec state-change bit whose wake-enable bit is also set.
- R3: Status bit 31 (global) is set when status bits 30..0 ANDed with control bits 30..0 are nonzero.
- R4: In level mode (`msg_en_i` = 0), `irq_line_o` is high exactly when status bit 31 and control bit 31 are both set. It changes on the same clock edge as the status word.
- R5: In message mode (`msg_en_i` = 1), `irq_line_o` stays low. `irq_msg_o` is high for one cycle on each clock edge where the computed level rises from 0 to 1.
- R6: A write with `wr_sel_i` = 2 clears every status bit that is set in `wr_data_i & 32'hC00000FF`. A cleared bit stays cleared until a source or an enable changes.
- R7: A change on a source input shows in the status word at the next clock edge. A change in a register (control, wake enable, codec state) shows one edge after the edge that wrote it.
- R8: A one-cycle `ctrl_rst_i` clears the control register, the wake enables, the status word and the output. It loads the codec state bits from `codec_present_i`, and the status word is recomputed on the following edge.
- R9: Each bit set in `codec_wake_i` sets the matching codec state bit, and the bit stays set. A write with `wr_sel_i` = 3 clears the codec state bits set in `wr_data_i[14:0]`. When a set and a clear hit the same bit on the same edge, the set wins.
- R10: A write with `wr_sel_i` = 1 loads the wake-enable mask from `wr_data_i[14:0]`.
- R11: A write with `wr_sel_i` = 0 loads the control register from `wr_data_i & 32'hC00000FF`. The other bits of the control register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_rst_i | input | 1 | Controller reset request, one cycle |
| codec_present_i | input | 15 | Map of attached codec addresses |
| codec_wake_i | input | 15 | State-change events per codec address |
| resp_irq_i | input | 1 | Response-ring interrupt flag |
| resp_ovr_i | input | 1 | Response-ring overrun flag |
| stream_done_i | input | 8 | Buffer completion flag per stream |
| msg_en_i | input | 1 | 1 selects message signalling, 0 selects level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 wake enable, 2 status clear, 3 codec state clear |
| wr_data_i | input | 32 | Write data |
| int_ctrl_o | output | 32 | Interrupt control register |
| int_status_o | output | 32 | Interrupt status word |
| codec_state_o | output | 15 | Codec state-change bits |
| irq_line_o | output | 1 | Level interrupt line |
| irq_msg_o | output | 1 | Message notification pulse |

## Verification
The bench clears the status word with write-one-to-clear while the stream flag behind it is still asserted. A design that recomputed every cycle would set the bit again at once, and a design that ignored the clear would keep the interrupt asserted. It writes an enable register and checks that the status word follows one edge later. A design that lost that dependency would hold a stale summary until some unrelated source moved. In message mode it checks that a level staying high gives exactly one pulse and that the wired line never rises. It also checks the set-versus-clear collision on the codec state bits, and that the summary is rebuilt from the attached-codec map after a controller reset. After the directed cases, random stimulus runs against the reference model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Bit positions of the two summary bits in the status word
    localparam int CTRL_SUM_BIT = 30;
    localparam int GLOBAL_BIT   = 31;

    // Write port targets
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_WAKE   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_CODEC  = 2'd3
    } wr_target_e;

    // Writable / clearable mask of control and status: summary bits plus stream bits
    function automatic logic [31:0] summary_mask(input int n_streams);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < n_streams; i++) m[i] = 1'b1;
        m[CTRL_SUM_BIT] = 1'b1;
        m[GLOBAL_BIT]   = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_src_summary.sv
module irq_src_summary
    import irq_agg_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int N_CODECS  = 15
) (
    input  logic [N_STREAMS-1:0] stream_done_i,
    input  logic                 resp_irq_i,
    input  logic                 resp_ovr_i,
    input  logic [N_CODECS-1:0]  codec_state_i,
    input  logic [N_CODECS-1:0]  wake_en_i,
    input  logic [31:0]          ctrl_i,
    output logic [31:0]          raw_status_o
);
    logic [31:0] lower_d;
    logic        ctrl_sum_d;

    // Per-stream completion bits
    for (genvar s = 0; s < 32; s++) begin : g_bit
        if (s < N_STREAMS) begin : g_stream
            assign lower_d[s] = stream_done_i[s];
        end else if (s == CTRL_SUM_BIT) begin : g_ctrl
            assign lower_d[s] = ctrl_sum_d;
        end else begin : g_zero
            assign lower_d[s] = 1'b0;
        end
    end

    always_comb begin
        ctrl_sum_d = resp_irq_i | resp_ovr_i | (|(codec_state_i & wake_en_i));
    end

    always_comb begin
        raw_status_o             = lower_d;
        raw_status_o[GLOBAL_BIT] = |(lower_d[30:0] & ctrl_i[30:0]);
    end

endmodule

// File: rtl/irq_change_detect.sv
module irq_change_detect #(
    parameter int SRC_W = 72
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [SRC_W-1:0] src_i,
    output logic             changed_o
);
    logic [SRC_W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d    = clear_i ? '0 : src_i;
        changed_o = (src_i != snap_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

endmodule

// File: rtl/irq_notify.sv
module irq_notify (
    input  logic clk,
    input  logic rst_n,
    input  logic msg_en_i,
    input  logic level_d_i,
    output logic irq_line_o,
    output logic irq_msg_o
);
    typedef struct packed {
        logic level;
        logic pulse;
    } notify_t;

    notify_t n_d, n_q;

    always_comb begin
        n_d.level = level_d_i;
        n_d.pulse = msg_en_i & level_d_i & ~n_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign irq_line_o = n_q.level & ~msg_en_i;
    assign irq_msg_o  = n_q.pulse;

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int N_CODECS  = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_rst_i,
    input  logic [N_CODECS-1:0]  codec_present_i,
    input  logic [N_CODECS-1:0]  codec_wake_i,
    input  logic                 resp_irq_i,
    input  logic                 resp_ovr_i,
    input  logic [N_STREAMS-1:0] stream_done_i,
    input  logic                 msg_en_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_sel_i,
    input  logic [31:0]          wr_data_i,
    output logic [31:0]          int_ctrl_o,
    output logic [31:0]          int_status_o,
    output logic [N_CODECS-1:0]  codec_state_o,
    output logic                 irq_line_o,
    output logic                 irq_msg_o
);
    localparam logic [31:0] SUM_MASK = summary_mask(N_STREAMS);
    localparam int          SRC_W    = 2 + N_STREAMS + 2 * N_CODECS + 32;

    typedef struct packed {
        logic [31:0]         ctrl;
        logic [N_CODECS-1:0] wake;
        logic [N_CODECS-1:0] codec;
        logic [31:0]         status;
    } agg_state_t;

    agg_state_t  st_d, st_q;
    wr_target_e  target;
    logic [31:0] raw_status;
    logic [SRC_W-1:0] src_vec;
    logic        src_changed;
    logic        level_d;

    assign target  = wr_target_e'(wr_sel_i);
    assign src_vec = {resp_irq_i, resp_ovr_i, stream_done_i, st_q.codec, st_q.wake, st_q.ctrl};

    irq_src_summary #(
        .N_STREAMS (N_STREAMS),
        .N_CODECS  (N_CODECS)
    ) u_summary (
        .stream_done_i (stream_done_i),
        .resp_irq_i    (resp_irq_i),
        .resp_ovr_i    (resp_ovr_i),
        .codec_state_i (st_q.codec),
        .wake_en_i     (st_q.wake),
        .ctrl_i        (st_q.ctrl),
        .raw_status_o  (raw_status)
    );

    irq_change_detect #(
        .SRC_W (SRC_W)
    ) u_change (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (ctrl_rst_i),
        .src_i     (src_vec),
        .changed_o (src_changed)
    );

    always_comb begin
        logic [31:0]         base;
        logic [31:0]         stat_clr;
        logic [N_CODECS-1:0] codec_clr;

        st_d      = st_q;
        stat_clr  = (wr_en_i && target == SEL_STATUS) ? (wr_data_i & SUM_MASK) : '0;
        codec_clr = (wr_en_i && target == SEL_CODEC) ? wr_data_i[N_CODECS-1:0] : '0;
        base      = src_changed ? raw_status : st_q.status;

        if (ctrl_rst_i) begin
            st_d.ctrl   = '0;
            st_d.wake   = '0;
            st_d.codec  = codec_present_i;
            st_d.status = '0;
        end else begin
            st_d.status = base & ~stat_clr;
            if (wr_en_i && target == SEL_CTRL) st_d.ctrl = wr_data_i & SUM_MASK;
            if (wr_en_i && target == SEL_WAKE) st_d.wake = wr_data_i[N_CODECS-1:0];
            st_d.codec = (st_q.codec & ~codec_clr) | codec_wake_i;
        end

        level_d = st_d.status[GLOBAL_BIT] & st_q.ctrl[GLOBAL_BIT] & ~ctrl_rst_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    irq_notify u_notify (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_en_i   (msg_en_i),
        .level_d_i  (level_d),
        .irq_line_o (irq_line_o),
        .irq_msg_o  (irq_msg_o)
    );

    assign int_ctrl_o    = st_q.ctrl;
    assign int_status_o  = st_q.status;
    assign codec_state_o = st_q.codec;

endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int N_STREAMS = 8,
    parameter int N_CODECS  = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctrl_rst_i,
    input logic [N_CODECS-1:0]  codec_present_i,
    input logic [N_CODECS-1:0]  codec_wake_i,
    input logic                 msg_en_i,
    input logic [31:0]          int_ctrl_o,
    input logic [31:0]          int_status_o,
    input logic [N_CODECS-1:0]  codec_state_o,
    input logic                 irq_line_o,
    input logic                 irq_msg_o
);
    localparam logic [31:0] SUM_MASK = summary_mask(N_STREAMS);

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_status_o & ~SUM_MASK) == '0));

    // R11
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_ctrl_o & ~SUM_MASK) == '0));

    // R4
    line_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line_o |-> int_status_o[GLOBAL_BIT]);

    // R5
    msg_mode_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_en_i |-> !irq_line_o);

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg_o |=> !irq_msg_o);

    // R5
    pulse_needs_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg_o |-> int_status_o[GLOBAL_BIT]);

    // R8
    ctrl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst_i |=> (int_status_o == '0 && int_ctrl_o == '0 && !irq_line_o
                        && codec_state_o == $past(codec_present_i)));

    // R9
    wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (codec_wake_i != '0 && !ctrl_rst_i) |=>
        ((codec_state_o & $past(codec_wake_i)) == $past(codec_wake_i)));

endmodule

bind irq_status_agg irq_status_agg_chk #(
    .N_STREAMS (N_STREAMS),
    .N_CODECS  (N_CODECS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctrl_rst_i      (ctrl_rst_i),
    .codec_present_i (codec_present_i),
    .codec_wake_i    (codec_wake_i),
    .msg_en_i        (msg_en_i),
    .int_ctrl_o      (int_ctrl_o),
    .int_status_o    (int_status_o),
    .codec_state_o   (codec_state_o),
    .irq_line_o      (irq_line_o),
    .irq_msg_o       (irq_msg_o)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_rst = 1'b0;
    logic [14:0] codec_present = '0;
    logic [14:0] codec_wake = '0;
    logic        resp_irq = 1'b0;
    logic        resp_ovr = 1'b0;
    logic [7:0]  stream_done = '0;
    logic        msg_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] int_ctrl, int_status;
    logic [14:0] codec_state;
    logic        irq_line, irq_msg;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_status_agg u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ctrl_rst_i      (ctrl_rst),
        .codec_present_i (codec_present),
        .codec_wake_i    (codec_wake),
        .resp_irq_i      (resp_irq),
        .resp_ovr_i      (resp_ovr),
        .stream_done_i   (stream_done),
        .msg_en_i        (msg_en),
        .wr_en_i         (wr_en),
        .wr_sel_i        (wr_sel),
        .wr_data_i       (wr_data),
        .int_ctrl_o      (int_ctrl),
        .int_status_o    (int_status),
        .codec_state_o   (codec_state),
        .irq_line_o      (irq_line),
        .irq_msg_o       (irq_msg)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    logic [31:0] m_ctrl = '0, m_status = '0;
    logic [14:0] m_wake = '0, m_codec = '0;
    logic        m_level = 0, m_pulse = 0;
    logic [71:0] m_seen = '0;

    always @(posedge clk) begin
        logic [71:0] now;
        logic [31:0] raw, nxt;
        if (!rst_n) begin
            m_ctrl = '0; m_status = '0; m_wake = '0; m_codec = '0;
            m_level = 0; m_pulse = 0; m_seen = '0;
        end else if (ctrl_rst) begin
            m_ctrl = '0; m_status = '0; m_wake = '0; m_codec = codec_present;
            m_level = 0; m_pulse = 0; m_seen = '0;
        end else begin
            now = {resp_irq, resp_ovr, stream_done, m_codec, m_wake, m_ctrl};
            raw = '0;
            for (int i = 0; i < 8; i++) raw[i] = stream_done[i];
            raw[30] = resp_irq || resp_ovr || ((m_codec & m_wake) != 0);
            raw[31] = ((raw[30:0] & m_ctrl[30:0]) != 0);
            nxt = (now != m_seen) ? raw : m_status;
            if (wr_en && wr_sel == 2) nxt = nxt & ~(wr_data & 32'hC00000FF);
            m_pulse = msg_en && nxt[31] && m_ctrl[31] && !m_level;
            m_level = nxt[31] && m_ctrl[31];
            m_status = nxt;
            m_seen = now;
            if (wr_en && wr_sel == 3) m_codec = m_codec & ~wr_data[14:0];
            m_codec = m_codec | codec_wake;
            if (wr_en && wr_sel == 0) m_ctrl = wr_data & 32'hC00000FF;
            if (wr_en && wr_sel == 1) m_wake = wr_data[14:0];
        end
    end

    // Compare with the model on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R1 R2 R3 R6 R7", "model status", int_status, m_status);
            chk("R11", "model ctrl", int_ctrl, m_ctrl);
            chk("R9 R10", "model codec", {17'd0, codec_state}, {17'd0, m_codec});
            chk("R4", "model line", {31'd0, irq_line}, {31'd0, m_level && !msg_en});
            chk("R5", "model pulse", {31'd0, irq_msg}, {31'd0, m_pulse});
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("reset", "status", int_status, 32'h0);
        chk("reset", "line", {31'd0, irq_line}, 32'h0);

        #1 wr(0, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R11", "ctrl mask", int_ctrl, 32'hC00000FF);

        #1 wr_en = 0; stream_done = 8'h04;
        @(negedge clk);
        chk("R1", "stream 2 status", int_status, 32'h80000004);
        chk("R4", "level line", {31'd0, irq_line}, 32'h1);

        #1 wr(2, 32'h8000_0004);
        @(negedge clk);
        chk("R6", "w1c clears", int_status, 32'h0);
        chk("R6", "w1c drops line", {31'd0, irq_line}, 32'h0);
        #1 wr_en = 0;
        repeat (3) @(negedge clk);
        chk("R6", "cleared bit holds", int_status, 32'h0);

        #1 stream_done = 8'h05;
        @(negedge clk);
        chk("R7", "next edge recompute", int_status, 32'h80000005);

        #1 msg_en = 1; stream_done = 8'h00;
        @(negedge clk);
        chk("R5", "level low", int_status, 32'h0);
        #1 stream_done = 8'h02;
        @(negedge clk);
        chk("R5", "pulse", {31'd0, irq_msg}, 32'h1);
        chk("R5", "line low in msg mode", {31'd0, irq_line}, 32'h0);
        @(negedge clk);
        chk("R5", "single pulse", {31'd0, irq_msg}, 32'h0);

        #1 ctrl_rst = 1; codec_present = 15'h0005;
        @(negedge clk);
        chk("R8", "codec map loaded", {17'd0, codec_state}, 32'h5);
        chk("R8", "ctrl cleared", int_ctrl, 32'h0);
        chk("R8", "status cleared", int_status, 32'h0);
        #1 ctrl_rst = 0; msg_en = 0; wr(1, 32'h1);
        @(negedge clk);
        #1 wr(0, 32'hC000_0000);
        @(negedge clk);
        chk("R10", "wake enable feeds summary", int_status, 32'h40000002);
        #1 wr_en = 0;
        @(negedge clk);
        chk("R2", "codec wake summary", int_status, 32'hC0000002);
        chk("R3", "global line", {31'd0, irq_line}, 32'h1);

        #1 codec_wake = 15'h0008; wr(3, 32'h9);
        @(negedge clk);
        chk("R9", "set wins, clear applies", {17'd0, codec_state}, 32'hC);
        #1 codec_wake = '0; wr_en = 0;
        @(negedge clk);
        chk("R2", "summary drops", int_status, 32'h00000002);
        #1 resp_ovr = 1;
        @(negedge clk);
        chk("R2", "overrun summary", int_status, 32'hC0000002);
        #1 resp_ovr = 0;

        // Random phase checked by the model
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            #1;
            stream_done = ($urandom % 4 == 0) ? 8'($urandom) : stream_done;
            resp_irq    = ($urandom % 8 == 0) ? ~resp_irq : resp_irq;
            resp_ovr    = ($urandom % 16 == 0) ? ~resp_ovr : resp_ovr;
            codec_wake  = ($urandom % 12 == 0) ? 15'(1 << ($urandom % 15)) : '0;
            msg_en      = ($urandom % 50 == 0) ? ~msg_en : msg_en;
            ctrl_rst    = ($urandom % 300 == 0);
            codec_present = 15'($urandom);
            wr_en       = ($urandom % 4 == 0);
            wr_sel      = 2'($urandom);
            wr_data     = $urandom;
        end
        @(negedge clk);
        #1 wr_en = 0; ctrl_rst = 0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule